// File: doc/BRIEF.md
# Firmware Root Redirector

This block sits between a host that issues firmware read and write requests and the external flash that holds the firmware. A fixed, aligned address window (the root window) is backed by a local shadow RAM that a boot-time loader fills with verified content through a dedicated load port. Host reads that land in that window are answered from the shadow RAM. Every other request, read or write, is handed to the flash request port unchanged, and the flash answer is returned to the host.

While the stall input is high, for example during boot-time loading and verification, requests into the root window are held off with `h_req_ready` low. Requests outside the window keep flowing. Writes into the root window are refused after every reset until a one-cycle unlock command arrives. An accepted root write is sent to the flash, but it never changes the shadow RAM, so the host keeps reading the old root content until the next boot reloads it. The block has one request in flight at a time, so responses come back in request order.

Top module: `fw_root_redirect`

## Requirements
- R1: A host read whose address lies in the root window is answered with the shadow entry at offset (address − ROOT_BASE). `h_rsp_valid` is high one cycle after acceptance, `h_rsp_err` is 0, and no flash request is made.
- R2: A request outside the root window, read or write, appears on the flash request port with the same address, write flag and write data. Its response carries the flash read data with `h_rsp_err` 0.
- R3: While `stall_i` is 1, a request into the root window is not accepted (`h_req_ready` 0). Requests outside the window are still accepted.
- R4: After reset `root_locked` is 1, and no response or flash request is pending. A root-window write made while locked is answered one cycle later with `h_rsp_err` 1 and `h_rsp_rdata` 0, and nothing is sent to the flash.
- R5: A one-cycle pulse on `unlock_i` clears `root_locked` from the next cycle. The lock stays clear until reset, and every reset sets it again.
- R6: A root-window write accepted while unlocked is forwarded to the flash like R2. The shadow RAM is not changed, so later root reads of that address return the previously loaded value.
- R7: When `sh_we` is 1, shadow entry `sh_idx` takes `sh_wdata` at the clock edge. A root read accepted in the same cycle as a load of the same entry returns the old value.
- R8: Only one request is handled at a time. From the acceptance of a forwarded request until the cycle its flash response arrives, `h_req_ready` is 0. Responses are returned in the order the requests were accepted.
- R9: A root-window write accepted in the same cycle as an `unlock_i` pulse is judged against the lock as it was before that cycle, so it is rejected as in R4.
- R10: The root window spans exactly ROOT_BASE to ROOT_BASE+ROOT_SIZE−1. The first and last addresses of the window are served locally. ROOT_BASE−1 and ROOT_BASE+ROOT_SIZE go to the flash.
- R11: `root_held` is 1 exactly when the block is idle and a valid root-window request is being held off by `stall_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Hold off root-window requests |
| unlock_i | input | 1 | One-cycle command that clears the root write lock |
| sh_we | input | 1 | Shadow RAM load strobe |
| sh_idx | input | log2(ROOT_SIZE) | Shadow entry to load |
| sh_wdata | input | DW | Shadow load data |
| h_req_valid | input | 1 | Host request valid |
| h_req_ready | output | 1 | Host request accepted when high with valid |
| h_req_we | input | 1 | Host request is a write |
| h_req_addr | input | AW | Host word address |
| h_req_wdata | input | DW | Host write data |
| h_rsp_valid | output | 1 | Host response valid (one cycle) |
| h_rsp_rdata | output | DW | Host response read data |
| h_rsp_err | output | 1 | Response marks a rejected root write |
| f_req_valid | output | 1 | Flash request valid |
| f_req_ready | input | 1 | Flash accepts request |
| f_req_we | output | 1 | Flash request is a write |
| f_req_addr | output | AW | Flash word address |
| f_req_wdata | output | DW | Flash write data |
| f_rsp_valid | input | 1 | Flash response valid (one per request) |
| f_rsp_rdata | input | DW | Flash response read data |
| root_locked | output | 1 | Root write lock status |
| root_held | output | 1 | A root request is held by stall |

## Verification
Two pairs of functions can meet in a single cycle. The first is an unlock pulse arriving together with the acceptance of a root write. The second is a shadow load of an entry arriving together with an accepted read of that same entry. The bench drives both on one falling edge while the block is idle, so the request is certain to be taken at the next rising edge. The reference model applies the lock test and the shadow read before it applies the unlock and the load. The rejection and the old data must then show up in the response of the following cycle, and the cleared lock and new data on the cycle after.

// File: rtl/fw_root_redirect.sv
module fw_root_redirect #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int ROOT_SIZE = 64,
  parameter logic [AW-1:0] ROOT_BASE = 'h4000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         stall_i,
  input  logic                         unlock_i,
  input  logic                         sh_we,
  input  logic [$clog2(ROOT_SIZE)-1:0] sh_idx,
  input  logic [DW-1:0]                sh_wdata,
  input  logic                         h_req_valid,
  output logic                         h_req_ready,
  input  logic                         h_req_we,
  input  logic [AW-1:0]                h_req_addr,
  input  logic [DW-1:0]                h_req_wdata,
  output logic                         h_rsp_valid,
  output logic [DW-1:0]                h_rsp_rdata,
  output logic                         h_rsp_err,
  output logic                         f_req_valid,
  input  logic                         f_req_ready,
  output logic                         f_req_we,
  output logic [AW-1:0]                f_req_addr,
  output logic [DW-1:0]                f_req_wdata,
  input  logic                         f_rsp_valid,
  input  logic [DW-1:0]                f_rsp_rdata,
  output logic                         root_locked,
  output logic                         root_held
);
  localparam int IW = $clog2(ROOT_SIZE);

  typedef enum logic [1:0] {IDLE, FL_REQ, FL_RSP} state_t;

  state_t        state;
  logic [DW-1:0] shadow [ROOT_SIZE];
  logic          locked;
  logic          rsp_v, rsp_e;
  logic [DW-1:0] rsp_d;
  logic [AW-1:0] fa;
  logic          fw;
  logic [DW-1:0] fd;
  logic          hit, take, rd_local, wr_reject;

  assign hit         = h_req_addr[AW-1:IW] == ROOT_BASE[AW-1:IW];
  assign h_req_ready = (state == IDLE) && !(hit && stall_i);
  assign take        = h_req_valid && h_req_ready;
  assign rd_local    = take && hit && !h_req_we;
  assign wr_reject   = take && hit && h_req_we && locked;
  assign root_held   = (state == IDLE) && h_req_valid && hit && stall_i;

  assign h_rsp_valid = rsp_v;
  assign h_rsp_rdata = rsp_d;
  assign h_rsp_err   = rsp_e;
  assign f_req_valid = (state == FL_REQ);
  assign f_req_we    = fw;
  assign f_req_addr  = fa;
  assign f_req_wdata = fd;
  assign root_locked = locked;

  always_ff @(posedge clk)
    if (sh_we) shadow[sh_idx] <= sh_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= IDLE;
      locked <= 1'b1;
      rsp_v  <= 1'b0;
      rsp_e  <= 1'b0;
      rsp_d  <= '0;
      fa     <= '0;
      fw     <= 1'b0;
      fd     <= '0;
    end else begin
      rsp_v <= 1'b0;
      if (unlock_i) locked <= 1'b0;
      unique case (state)
        IDLE:
          if (rd_local) begin
            rsp_v <= 1'b1;
            rsp_e <= 1'b0;
            rsp_d <= shadow[h_req_addr[IW-1:0]];
          end else if (wr_reject) begin
            rsp_v <= 1'b1;
            rsp_e <= 1'b1;
            rsp_d <= '0;
          end else if (take) begin
            state <= FL_REQ;
            fa    <= h_req_addr;
            fw    <= h_req_we;
            fd    <= h_req_wdata;
          end
        FL_REQ:
          if (f_req_ready) state <= FL_RSP;
        FL_RSP:
          if (f_rsp_valid) begin
            rsp_v <= 1'b1;
            rsp_e <= 1'b0;
            rsp_d <= f_rsp_rdata;
            state <= IDLE;
          end
        default: state <= IDLE;
      endcase
    end
endmodule

module fw_root_redirect_chk #(
  parameter int AW = 16,
  parameter int ROOT_SIZE = 64,
  parameter logic [AW-1:0] ROOT_BASE = 'h4000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall_i,
  input logic          unlock_i,
  input logic          h_req_valid,
  input logic          h_req_ready,
  input logic          h_req_we,
  input logic [AW-1:0] h_req_addr,
  input logic          h_rsp_valid,
  input logic          h_rsp_err,
  input logic          f_req_valid,
  input logic          f_req_ready,
  input logic          f_req_we,
  input logic [AW-1:0] f_req_addr,
  input logic          root_locked,
  input logic          root_held
);
  logic [AW:0] lo, hi;
  logic        h_in, f_in;
  assign lo   = {1'b0, ROOT_BASE};
  assign hi   = lo + (AW+1)'(ROOT_SIZE);
  assign h_in = ({1'b0, h_req_addr} >= lo) && ({1'b0, h_req_addr} < hi);
  assign f_in = ({1'b0, f_req_addr} >= lo) && ({1'b0, f_req_addr} < hi);

  AST_ROOT_READ_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    h_req_valid && h_req_ready && !h_req_we && h_in |=> h_rsp_valid && !h_rsp_err && !f_req_valid); // R1
  AST_NO_ROOT_READ_TO_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
    f_req_valid |-> f_req_we || !f_in); // R1
  AST_FLASH_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    f_req_valid && !f_req_ready |=> f_req_valid && $stable(f_req_addr) && $stable(f_req_we)); // R2
  AST_STALL_HOLDS_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i && h_in |-> !h_req_ready); // R3
  AST_LOCKED_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> root_locked); // R4
  AST_LOCKED_WRITE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    h_req_valid && h_req_ready && h_req_we && h_in && root_locked |=> h_rsp_valid && h_rsp_err && !f_req_valid); // R4
  AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_i |=> !root_locked); // R5
  AST_LOCK_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !root_locked |=> !root_locked); // R5
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    f_req_valid |-> !h_req_ready); // R8
  AST_HELD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    root_held |-> !h_req_ready && stall_i && h_in); // R11
endmodule

bind fw_root_redirect fw_root_redirect_chk #(
  .AW(AW), .ROOT_SIZE(ROOT_SIZE), .ROOT_BASE(ROOT_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .unlock_i(unlock_i),
  .h_req_valid(h_req_valid), .h_req_ready(h_req_ready), .h_req_we(h_req_we),
  .h_req_addr(h_req_addr), .h_rsp_valid(h_rsp_valid), .h_rsp_err(h_rsp_err),
  .f_req_valid(f_req_valid), .f_req_ready(f_req_ready), .f_req_we(f_req_we),
  .f_req_addr(f_req_addr), .root_locked(root_locked), .root_held(root_held)
);

// File: tb/fw_root_redirect_tb.sv
module fw_root_redirect_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SZ = 64;
  localparam int IW = 6;
  localparam logic [15:0] BASE = 16'h4000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, stall_i = 1'b0, unlock_i = 1'b0;
  logic sh_we = 1'b0;
  logic [IW-1:0] sh_idx = '0;
  logic [DW-1:0] sh_wdata = '0;
  logic h_req_valid = 1'b0, h_req_we = 1'b0;
  logic [AW-1:0] h_req_addr = '0;
  logic [DW-1:0] h_req_wdata = '0;
  logic h_req_ready, h_rsp_valid, h_rsp_err;
  logic [DW-1:0] h_rsp_rdata;
  logic f_req_valid, f_req_we;
  logic [AW-1:0] f_req_addr;
  logic [DW-1:0] f_req_wdata;
  logic f_req_ready = 1'b0, f_rsp_valid = 1'b0;
  logic [DW-1:0] f_rsp_rdata = '0;
  logic root_locked, root_held;

  fw_root_redirect #(.AW(AW), .DW(DW), .ROOT_SIZE(SZ), .ROOT_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .unlock_i(unlock_i),
    .sh_we(sh_we), .sh_idx(sh_idx), .sh_wdata(sh_wdata),
    .h_req_valid(h_req_valid), .h_req_ready(h_req_ready), .h_req_we(h_req_we),
    .h_req_addr(h_req_addr), .h_req_wdata(h_req_wdata),
    .h_rsp_valid(h_rsp_valid), .h_rsp_rdata(h_rsp_rdata), .h_rsp_err(h_rsp_err),
    .f_req_valid(f_req_valid), .f_req_ready(f_req_ready), .f_req_we(f_req_we),
    .f_req_addr(f_req_addr), .f_req_wdata(f_req_wdata),
    .f_rsp_valid(f_rsp_valid), .f_rsp_rdata(f_rsp_rdata),
    .root_locked(root_locked), .root_held(root_held));

  // reference model state
  logic [31:0] sh_m [SZ];
  bit          wr_m [SZ];
  bit lock_m = 1'b1, busy_m = 1'b0, acc_flag = 1'b0;
  logic [31:0] er_d[$];
  bit          er_e[$];
  string       er_t[$];
  logic [15:0] ef_a[$];
  bit          ef_w[$];
  logic [31:0] ef_d[$];
  string       ef_t[$];
  int n_chk = 0, n_bad = 0, fl_cnt = 0, cyc = 0;
  logic [31:0] fl_data = '0;
  bit wd = 1'b0;

  function automatic bit inr(logic [15:0] a);
    return (int'(a) >= int'(BASE)) && (int'(a) < int'(BASE) + SZ);
  endfunction

  function automatic logic [31:0] ffn(logic [15:0] a);
    return {16'hF1A5, a};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // flash device model: fixed two-cycle answer, ready drops every third cycle
  always @(negedge clk) begin
    cyc++;
    f_rsp_valid = 1'b0;
    f_req_ready = (cyc % 3) != 1;
    if (!rst_n) fl_cnt = 0;
    else if (fl_cnt > 0) begin
      fl_cnt--;
      if (fl_cnt == 0) begin
        f_rsp_valid = 1'b1;
        f_rsp_rdata = fl_data;
      end
    end
  end

  logic [IW-1:0] ix;
  bit  exp_rdy, exp_held, rin;
  string tg;

  // monitor: samples 1 ns before each rising edge
  always begin
    @(negedge clk); #3;
    if (!rst_n) begin
      lock_m = 1'b1; busy_m = 1'b0; acc_flag = 1'b0;
      er_d.delete(); er_e.delete(); er_t.delete();
      ef_a.delete(); ef_w.delete(); ef_d.delete(); ef_t.delete();
    end else begin
      rin = inr(h_req_addr);
      chk(root_locked === lock_m, "R5 root_locked", 32'(root_locked), 32'(lock_m));
      exp_rdy = !busy_m && !(rin && stall_i);
      chk(h_req_ready === exp_rdy, (rin && stall_i) ? "R3 ready under stall" : "R8 ready",
          32'(h_req_ready), 32'(exp_rdy));
      exp_held = !busy_m && h_req_valid && rin && stall_i;
      chk(root_held === exp_held, "R11 root_held", 32'(root_held), 32'(exp_held));
      if (h_rsp_valid) begin
        if (er_d.size() == 0) chk(1'b0, "R8 unexpected response", h_rsp_rdata, 32'h0);
        else begin
          tg = er_t.pop_front();
          chk(h_rsp_rdata === er_d[0], {tg, " rdata"}, h_rsp_rdata, er_d[0]);
          chk(h_rsp_err === er_e[0], {tg, " err"}, 32'(h_rsp_err), 32'(er_e[0]));
          void'(er_d.pop_front()); void'(er_e.pop_front());
        end
      end
      if (f_req_valid && f_req_ready) begin
        if (ef_a.size() == 0) chk(1'b0, "R4 unexpected flash request", 32'(f_req_addr), 32'h0);
        else begin
          tg = ef_t.pop_front();
          chk(f_req_addr === ef_a[0], {tg, " flash addr"}, 32'(f_req_addr), 32'(ef_a[0]));
          chk(f_req_we === ef_w[0], {tg, " flash we"}, 32'(f_req_we), 32'(ef_w[0]));
          chk(f_req_wdata === ef_d[0], {tg, " flash wdata"}, f_req_wdata, ef_d[0]);
          void'(ef_a.pop_front()); void'(ef_w.pop_front()); void'(ef_d.pop_front());
        end
        fl_cnt = 2;
        fl_data = ffn(f_req_addr);
      end
      if (f_rsp_valid) busy_m = 1'b0;
      acc_flag = h_req_valid && h_req_ready;
      if (acc_flag) begin
        ix = IW'(h_req_addr - BASE);
        if (rin && !h_req_we) begin
          er_d.push_back(sh_m[ix]); er_e.push_back(1'b0);
          if (sh_we && sh_idx == ix) er_t.push_back("R7 load/read same cycle");
          else if (wr_m[ix]) er_t.push_back("R6 shadow unchanged by write");
          else if (ix == 0 || ix == IW'(SZ-1)) er_t.push_back("R10 window edge local");
          else er_t.push_back("R1 root read");
        end else if (rin && lock_m) begin
          er_d.push_back(32'h0); er_e.push_back(1'b1);
          er_t.push_back(unlock_i ? "R9 unlock same cycle" : "R4 locked write");
        end else begin
          ef_a.push_back(h_req_addr); ef_w.push_back(h_req_we); ef_d.push_back(h_req_wdata);
          if (rin) ef_t.push_back("R6 unlocked root write");
          else if (h_req_addr == BASE - 16'd1 || h_req_addr == BASE + 16'(SZ))
            ef_t.push_back("R10 window edge forwarded");
          else ef_t.push_back("R2 passthrough");
          er_d.push_back(ffn(h_req_addr)); er_e.push_back(1'b0); er_t.push_back("R2 flash response");
          busy_m = 1'b1;
          if (rin) wr_m[ix] = 1'b1;
        end
      end
      if (sh_we) begin
        sh_m[sh_idx] = sh_wdata;
        wr_m[sh_idx] = 1'b0;
      end
      if (unlock_i) lock_m = 1'b0;
    end
  end

  task automatic wait_acc();
    do @(negedge clk); while (!acc_flag);
    h_req_valid = 1'b0;
  endtask

  task automatic send(bit we, logic [15:0] a, logic [31:0] d);
    h_req_valid = 1'b1; h_req_we = we; h_req_addr = a; h_req_wdata = d;
    wait_acc();
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1); #3;
    chk(h_rsp_valid === 1'b0 && f_req_valid === 1'b0 && root_locked === 1'b1,
        "R4 reset state", {29'b0, h_rsp_valid, f_req_valid, root_locked}, 32'h1);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < SZ; i++) begin sh_m[i] = 32'hx; wr_m[i] = 1'b0; end
    fork
      begin
        @(negedge clk);
        do_reset();
        stall_i = 1'b1;
        for (int i = 0; i < SZ; i++) begin
          sh_we = 1'b1; sh_idx = IW'(i); sh_wdata = 32'hC0DE0000 + 32'(i * 7);
          @(negedge clk);
        end
        sh_we = 1'b0;
        stall_i = 1'b0;
        send(1'b0, BASE, 0);
        send(1'b0, BASE + 16'd1, 0);
        send(1'b0, BASE + 16'd2, 0);
        send(1'b0, BASE + 16'(SZ - 1), 0);
        send(1'b0, BASE - 16'd1, 0);
        send(1'b0, BASE + 16'(SZ), 0);
        send(1'b0, 16'h0123, 0);
        send(1'b1, 16'h8000, 32'h12345678);
        send(1'b1, BASE + 16'd3, 32'hBAD0BAD0);
        send(1'b0, BASE + 16'd3, 0);
        idle(6);
        // stall holds a root read, passthrough still flows
        stall_i = 1'b1;
        h_req_valid = 1'b1; h_req_we = 1'b0; h_req_addr = BASE + 16'd9;
        idle(3);
        stall_i = 1'b0;
        wait_acc();
        stall_i = 1'b1;
        send(1'b0, 16'h1234, 0);
        stall_i = 1'b0;
        idle(6);
        // unlock together with a root write
        unlock_i = 1'b1;
        h_req_valid = 1'b1; h_req_we = 1'b1; h_req_addr = BASE + 16'd4; h_req_wdata = 32'h44;
        wait_acc();
        unlock_i = 1'b0;
        send(1'b1, BASE + 16'd4, 32'h5555AAAA);
        send(1'b0, BASE + 16'd4, 0);
        idle(6);
        // load and read the same entry together
        sh_we = 1'b1; sh_idx = IW'(5); sh_wdata = 32'hDEAD0005;
        send(1'b0, BASE + 16'd5, 0);
        sh_we = 1'b0;
        send(1'b0, BASE + 16'd5, 0);
        send(1'b0, BASE + 16'd6, 0);
        send(1'b0, BASE + 16'd7, 0);
        idle(6);
        do_reset();
        send(1'b1, BASE + 16'd8, 32'h88);
        send(1'b0, BASE + 16'd8, 0);
        idle(8);
        #3;
        chk(er_d.size() == 0 && ef_a.size() == 0, "R8 all responses delivered",
            32'(er_d.size() + ef_a.size()), 32'h0);
      end
      begin
        repeat (20000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog expired actual=%0d expected=0", 1);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule